// File: doc/BRIEF.md
# TDM Frame Timing Generator

This block keeps the position within one 125 µs TDM frame as a counter clocked by the 65.536 MHz master clock. From that position it derives the timing signals the rest of a TDM bus interface uses. A non-inverted bus-rate clock runs at half the master rate. An inverted state clock runs at a quarter of the master rate. A sync pulse straddles every frame boundary, with half of it before the boundary and half after. The current frame position is also a port, so an alignment controller can measure the frame phase.

In slave mode the alignment controller can adjust the frame in two ways. A snap command restarts the frame at once. A shorten command, sampled at the first count of a frame, removes one master cycle from that frame only. Repeating the shorten command slides the generated frame edge toward a reference one cycle per frame. In master mode the block runs freely and acts as the frame reference, and it ignores both commands. All pins are plain control and status signals. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `frame_timing_gen`

## Requirements
- R1: After reset, `frame_pos` advances by one each master cycle from 0 to FRAME_LEN-1 and then returns to 0, so a nominal frame lasts FRAME_LEN cycles.
- R2: `bus_clk` equals bit 0 of `frame_pos`: it is a divide-by-2 clock that is low at count 0.
- R3: `state_clk_n` equals the inverse of bit 1 of `frame_pos`: it is an inverted divide-by-4 clock that is high at counts 0 and 1.
- R4: `sync_pulse` is high exactly when `frame_pos` is in FRAME_LEN-SYNC_HALF..FRAME_LEN-1 or in 0..SYNC_HALF-1. This gives 2*SYNC_HALF cycles centred on the frame boundary.
- R5: In slave mode, `shorten_req` high on a cycle where `frame_pos` is 0 makes the next `frame_pos` 2. Count 1 is skipped and only that frame is one cycle shorter. `shorten_req` has no effect at any other count.
- R6: In slave mode, `snap_req` high makes the next `frame_pos` 0, and the derived outputs take their count-0 levels. When both requests are high, `snap_req` wins over `shorten_req`.
- R7: While `master_mode` is high, `snap_req` and `shorten_req` are ignored and the counter runs freely as in R1.
- R8: A clock edge with `rst` high sets `frame_pos` to 0, `bus_clk` to 0, `state_clk_n` to 1 and `sync_pulse` to 1, which are the count-0 levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 65.536 MHz master clock |
| rst | input | 1 | synchronous reset, active high |
| master_mode | input | 1 | 1: free-running frame reference; 0: slave, requests honoured |
| snap_req | input | 1 | restart the frame at count 0 on the next cycle |
| shorten_req | input | 1 | cut the current frame by one cycle if seen at count 0 |
| frame_pos | output | $clog2(FRAME_LEN) | current frame position (phase report) |
| bus_clk | output | 1 | non-inverted divide-by-2 bus-rate clock |
| state_clk_n | output | 1 | inverted divide-by-4 state clock |
| sync_pulse | output | 1 | frame sync pulse centred on the frame boundary |

## Verification
The hardest case to reach is a request that arrives at one particular frame phase. A shorten request acts only when it coincides with count 0. A snap request arriving on the last count must give the same result as an ordinary wrap. The bench uses a 32-cycle frame. It walks the count to each of the 32 positions in turn and issues a one-cycle shorten there, then does the same for a snap. It also issues both requests together at count 0 and applies both while in master mode. A reference count kept in the bench predicts every output on every cycle.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_SNAP    = 2'd1,
    CMD_SHORTEN = 2'd2
  } ftg_cmd_e;

  // Snap outranks shorten; master mode blanks both.
  function automatic ftg_cmd_e decode_cmd(input logic master, input logic snap,
                                          input logic shorten);
    if (master)       return CMD_NONE;
    else if (snap)    return CMD_SNAP;
    else if (shorten) return CMD_SHORTEN;
    else              return CMD_NONE;
  endfunction

endpackage

// File: rtl/ftg_counter.sv
module ftg_counter
  import ftg_pkg::*;
#(
  parameter int FRAME_LEN = 8192,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  ftg_cmd_e      cmd,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] SKIP = CW'(2);

  always_comb begin
    if (cmd == CMD_SNAP)                           cnt_nxt = '0;
    else if (cnt_q == LAST)                        cnt_nxt = '0;
    else if (cmd == CMD_SHORTEN && cnt_q == '0)    cnt_nxt = SKIP;
    else                                           cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // R1: ordinary step inside a frame
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_SNAP && cnt_q != LAST && !(cmd == CMD_SHORTEN && cnt_q == '0))
      |=> cnt_q == $past(cnt_q) + CW'(1));

  // R1: wrap at the end of the frame
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> cnt_q == '0);

  // R5: shortened frame skips count 1
  p_shorten_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SHORTEN && cnt_q == '0) |=> cnt_q == SKIP);

  // R6: snap restarts the frame
  p_snap_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SNAP) |=> cnt_q == '0);

endmodule

// File: rtl/ftg_clkdiv.sv
module ftg_clkdiv #(
  parameter int          STAGES   = 2,
  parameter logic [STAGES-1:0] INV_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] cnt_nxt_lo,
  output logic [STAGES-1:0] div_q
);

  // Each tap i is a divide-by-2^(i+1) clock taken from counter bit i.
  // The reset level equals the tap value at count 0.
  for (genvar i = 0; i < STAGES; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) div_q[i] <= INV_MASK[i];
      else     div_q[i] <= cnt_nxt_lo[i] ^ INV_MASK[i];
    end

    // R2/R3: every tap flips only when its counter bit changes
    p_tap_follow_r2: assert property (@(posedge clk) disable iff (rst)
      (cnt_nxt_lo[i] ^ INV_MASK[i]) == div_q[i] |=> $stable(div_q[i]));
  end

endmodule

// File: rtl/ftg_sync.sv
module ftg_sync #(
  parameter int FRAME_LEN = 8192,
  parameter int SYNC_HALF = 4,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_nxt,
  output logic          sync_q
);

  localparam logic [CW-1:0] WIN_HI = CW'(FRAME_LEN - SYNC_HALF);
  localparam logic [CW-1:0] WIN_LO = CW'(SYNC_HALF);

  logic in_win;
  assign in_win = (cnt_nxt >= WIN_HI) || (cnt_nxt < WIN_LO);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b1;
    else     sync_q <= in_win;
  end

  // R4: the pulse cannot outlast its window on a nominal frame
  p_sync_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_nxt == WIN_LO) |=> !sync_q);

endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import ftg_pkg::*;
#(
  parameter int FRAME_LEN = 8192,
  parameter int SYNC_HALF = 4,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master_mode,
  input  logic          snap_req,
  input  logic          shorten_req,
  output logic [CW-1:0] frame_pos,
  output logic          bus_clk,
  output logic          state_clk_n,
  output logic          sync_pulse
);

  localparam int DIV_STAGES = 2;
  localparam logic [DIV_STAGES-1:0] DIV_INV = 2'b10;
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  ftg_cmd_e cmd;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [DIV_STAGES-1:0] div_q;

  assign cmd = decode_cmd(master_mode, snap_req, shorten_req);

  ftg_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
    .clk(clk), .rst(rst), .cmd(cmd), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  ftg_clkdiv #(.STAGES(DIV_STAGES), .INV_MASK(DIV_INV)) u_div (
    .clk(clk), .rst(rst), .cnt_nxt_lo(cnt_nxt[DIV_STAGES-1:0]), .div_q(div_q)
  );

  ftg_sync #(.FRAME_LEN(FRAME_LEN), .SYNC_HALF(SYNC_HALF)) u_sync (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .sync_q(sync_pulse)
  );

  assign frame_pos   = cnt_q;
  assign bus_clk     = div_q[0];
  assign state_clk_n = div_q[1];

  // R2: bus clock tracks count bit 0
  p_busclk_r2: assert property (@(posedge clk) disable iff (rst)
    bus_clk == frame_pos[0]);

  // R3: inverted state clock tracks count bit 1
  p_stclk_r3: assert property (@(posedge clk) disable iff (rst)
    state_clk_n == !frame_pos[1]);

  // R4: sync window straddles the boundary
  p_sync_r4: assert property (@(posedge clk) disable iff (rst)
    sync_pulse == (frame_pos >= CW'(FRAME_LEN - SYNC_HALF) || frame_pos < CW'(SYNC_HALF)));

  // R7: master mode free-runs whatever the requests
  p_master_r7: assert property (@(posedge clk) disable iff (rst)
    (master_mode && frame_pos != LAST) |=> frame_pos == $past(frame_pos) + CW'(1));

  // R8: reset lands on count-0 levels
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (frame_pos == '0 && !bus_clk && state_clk_n && sync_pulse));

endmodule

// File: tb/tb_frame_timing_gen.sv
module tb_frame_timing_gen;
  localparam int L = 32;
  localparam int H = 4;
  localparam int CW = $clog2(L);

  logic clk = 1'b0, rst = 1'b1;
  logic master_mode = 1'b0, snap_req = 1'b0, shorten_req = 1'b0;
  logic [CW-1:0] frame_pos;
  logic bus_clk, state_clk_n, sync_pulse;

  int compared = 0, mismatched = 0, exp_pos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  frame_timing_gen #(.FRAME_LEN(L), .SYNC_HALF(H)) dut (
    .clk(clk), .rst(rst), .master_mode(master_mode), .snap_req(snap_req),
    .shorten_req(shorten_req), .frame_pos(frame_pos), .bus_clk(bus_clk),
    .state_clk_n(state_clk_n), .sync_pulse(sync_pulse)
  );

  task automatic chk(string tag, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(bit m, bit sn, bit sh, string tag);
    master_mode = m; snap_req = sn; shorten_req = sh;
    @(posedge clk);
    if (rst)                        exp_pos = 0;
    else if (!m && sn)              exp_pos = 0;
    else if (exp_pos == L - 1)      exp_pos = 0;
    else if (!m && sh && exp_pos == 0) exp_pos = 2;
    else                            exp_pos++;
    @(negedge clk);
    chk(tag, int'(frame_pos), exp_pos);
    chk("R2 bus_clk", int'(bus_clk), exp_pos % 2);
    chk("R3 state_clk_n", int'(state_clk_n), int'(((exp_pos / 2) % 2) == 0));
    chk("R4 sync_pulse", int'(sync_pulse), int'(exp_pos >= L - H || exp_pos < H));
  endtask

  task automatic go_to(int p);
    while (exp_pos != p) step(0, 0, 0, "R1 frame_pos");
  endtask

  initial begin
    @(negedge clk);
    step(0, 0, 0, "R8 reset frame_pos");
    step(0, 1, 1, "R8 reset frame_pos");
    rst = 1'b0;
    for (int k = 0; k < 3 * L; k++) step(0, 0, 0, "R1 frame_pos");
    for (int k = 0; k < 2 * L; k++) step(1, (k % 3) == 0, (k % 5) != 1, "R7 frame_pos");
    for (int p = 0; p < L; p++) begin
      go_to(p);
      step(0, 0, 1, "R5 frame_pos");
      step(0, 0, 0, "R5 frame_pos");
    end
    for (int p = 0; p < L; p++) begin
      go_to(p);
      step(0, 1, 0, "R6 frame_pos");
      step(0, 0, 0, "R6 frame_pos");
    end
    go_to(0);
    step(0, 1, 1, "R6 priority frame_pos");
    step(0, 0, 0, "R6 priority frame_pos");
    go_to(17);
    rst = 1'b1;
    step(0, 0, 0, "R8 midframe reset frame_pos");
    rst = 1'b0;
    for (int k = 0; k < L + 3; k++) step(0, 0, 0, "R1 frame_pos");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule